// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Array

This block is a square grid of N×N multiply-accumulate cells that keeps one tile of weights in place and streams activation vectors through it. Each accepted input vector of N activations is multiplied by the resident N×N weight tile. The result is an N-element vector of 32-bit column sums, and every element of it leaves on the same cycle. Activations enter with a per-row delay and travel right along their row. Partial sums travel down their column and are realigned at the bottom. Once the pipeline is full, with 8-bit operands, one result vector leaves every clock.

A second bank of weight registers sits behind the active tile. A new tile is shifted into it one row per cycle while the active tile keeps computing. A swap request copies the shadow bank into the active bank at the next point where no vector is in flight against the old tile. Each operand has a signedness select and an 8/16-bit width select. A 16-bit operand is split into byte slices that take separate passes through the grid. The pass results are shifted and summed at the output, so throughput drops to one half or one quarter of the full rate.

Top module: `ws_systolic_array`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and both weight banks hold zero, so a vector accepted before any swap yields an all-zero result.
- R2: With both operands 8-bit, output element j equals the sum over i of a_i·w[i][j] modulo 2^32. a_i is bits [16i+7:16i] of in_data, and w[i][j] is bits [16j+7:16j] of the row-i load word. Each operand is read as two's complement when its signed select is 1 and as unsigned otherwise. The upper byte of every 16-bit lane is ignored.
- R3: With both operands 8-bit, a vector accepted in cycle t gives exactly one out_valid pulse in cycle t+2N, and in_ready stays 1, so vectors are accepted on consecutive cycles.
- R4: With exactly one operand 16-bit (full lane, two's complement or unsigned per its select), in_ready is 0 in the cycle after an accept, and the result appears in cycle t+2N+1.
- R5: With both operands 16-bit, in_ready is 0 for the three cycles after an accept, and the result appears in cycle t+2N+3. The result equals the exact 16×16 dot product modulo 2^32.
- R6: Each cycle with ld_valid high shifts the shadow bank by one row. After N loads, the first word loaded is row 0 and the last is row N−1. Loading never changes the results of vectors computed on the active tile.
- R7: In the cycle after swap_req, in_ready is 0. It stays 0 until every vector accepted before the request has produced its result, and the active tile changes only while no vector is in flight. Vectors accepted afterwards use the new tile.
- R8: out_valid pulses exactly once for each accepted vector, in acceptance order, and never without a pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Activation vector offered |
| in_ready | output | 1 | Vector accepted this cycle when in_valid is also high |
| in_data | input | N*16 | Activation lanes, lane i at bits [16i+15:16i] |
| a_sgn | input | 1 | Activations are two's complement |
| w_sgn | input | 1 | Weights are two's complement |
| a_wide | input | 1 | Activations use all 16 bits |
| w_wide | input | 1 | Weights use all 16 bits |
| ld_valid | input | 1 | Shift one weight row into the shadow bank |
| ld_row | input | N*16 | Weight row, column j at bits [16j+15:16j] |
| swap_req | input | 1 | Request shadow-to-active tile swap |
| out_valid | output | 1 | Result vector valid |
| out_data | output | N*32 | Result, column j at bits [32j+31:32j] |

## Verification
A wrong pass counter or a stuck swap flag shows at in_ready within one cycle of the accept or request, because its stall pattern is fixed by the mode bits. A mis-skewed row, a wrong deskew depth or a wrong byte slice corrupts out_data on the first affected result, 2N to 2N+3 cycles after the vector goes in. A tag pipeline of the wrong length moves out_valid off its exact cycle. A swap committed too early mixes two tiles in a result that is already in flight. The bench therefore compares in_ready and out_valid on every cycle and out_data on every valid cycle.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int OP_W    = 16;
    localparam int BYTE_W  = 8;
    localparam int SLICE_W = 9;
    localparam int PROD_W  = 2 * SLICE_W;
    localparam int SUM_W   = 32;

    // one activation slice travelling along a row, with the weight-slice
    // selection that the cells of that row must apply for the same pass
    typedef struct packed {
        logic [SLICE_W-1:0] val;
        logic               hi_w;
        logic               ext_w;
    } lane_t;

    // per-pass control travelling beside the column sums
    typedef struct packed {
        logic       vld;
        logic       first;
        logic       last;
        logic [4:0] shamt;
    } tag_t;

    typedef struct packed {
        logic a_sgn;
        logic w_sgn;
        logic a_wide;
        logic w_wide;
    } mode_t;

    // pick a byte of a 16-bit operand and widen it to a 9-bit signed slice
    function automatic logic [SLICE_W-1:0] slice9(input logic [OP_W-1:0] x,
                                                  input logic hi,
                                                  input logic ext);
        logic [BYTE_W-1:0] b;
        b = hi ? x[OP_W-1:BYTE_W] : x[BYTE_W-1:0];
        return {ext & b[BYTE_W-1], b};
    endfunction

    // the low byte of a 16-bit operand is always unsigned
    function automatic logic ext_bit(input logic sgn, input logic wide, input logic hi);
        return hi ? sgn : (sgn & ~wide);
    endfunction

    function automatic logic [2:0] pass_count(input mode_t m);
        case ({m.a_wide, m.w_wide})
            2'b00:   return 3'd1;
            2'b11:   return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/ws_issue.sv
module ws_issue
    import ws_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [N-1:0][OP_W-1:0]   in_vec,
    input  mode_t                    mode_i,
    input  logic                     hold,
    output logic                     in_ready,
    output logic                     accept,
    output lane_t [N-1:0]            lanes_o,
    output tag_t                     tag_o
);

    logic [1:0]              pass_q;
    logic [N-1:0][OP_W-1:0]  vec_q;
    mode_t                   mode_q;

    logic                    busy;
    mode_t                   cm;
    logic [N-1:0][OP_W-1:0]  cv;
    logic [2:0]              np;
    logic                    ahi, whi, aext, wext, vld, at_end;

    always_comb begin
        busy     = (pass_q != 2'd0);
        in_ready = !busy && !hold;
        accept   = in_valid && in_ready;
        cm       = busy ? mode_q : mode_i;
        cv       = busy ? vec_q  : in_vec;
        np       = pass_count(cm);
        at_end   = ({1'b0, pass_q} == (np - 3'd1));
        ahi      = cm.a_wide & pass_q[0];
        whi      = cm.w_wide & (cm.a_wide ? pass_q[1] : pass_q[0]);
        aext     = ext_bit(cm.a_sgn, cm.a_wide, ahi);
        wext     = ext_bit(cm.w_sgn, cm.w_wide, whi);
        vld      = busy || accept;

        tag_o.vld   = vld;
        tag_o.first = !busy;
        tag_o.last  = at_end;
        tag_o.shamt = {ahi & whi, ahi ^ whi, 3'b000};

        for (int i = 0; i < N; i++) begin
            lanes_o[i].val   = vld ? slice9(cv[i], ahi, aext) : '0;
            lanes_o[i].hi_w  = whi;
            lanes_o[i].ext_w = wext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_q <= 2'd0;
            vec_q  <= '0;
            mode_q <= '0;
        end else if (accept) begin
            vec_q  <= in_vec;
            mode_q <= mode_i;
            pass_q <= (np == 3'd1) ? 2'd0 : 2'd1;
        end else if (busy) begin
            pass_q <= at_end ? 2'd0 : pass_q + 2'd1;
        end
    end

endmodule

// File: rtl/ws_cell.sv
module ws_cell
    import ws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_t             a_in,
    input  logic [OP_W-1:0]   w_word,
    input  logic [SUM_W-1:0]  ps_in,
    output logic [SUM_W-1:0]  ps_out
);

    logic [SLICE_W-1:0]        w9;
    logic signed [PROD_W-1:0]  prod;

    always_comb begin
        w9   = slice9(w_word, a_in.hi_w, a_in.ext_w);
        prod = $signed(a_in.val) * $signed(w9);
    end

    always_ff @(posedge clk) begin
        if (rst) ps_out <= '0;
        else     ps_out <= ps_in + {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

endmodule

// File: rtl/ws_grid.sv
module ws_grid
    import ws_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  lane_t [N-1:0]                    lanes_in,
    input  logic [N-1:0][N-1:0][OP_W-1:0]    tile,
    output logic [N-1:0][SUM_W-1:0]          sums_out
);

    lane_t             ah [N][N];
    logic [SUM_W-1:0]  pv [N+1][N];

    // input skew: row i waits i cycles
    for (genvar i = 0; i < N; i++) begin : g_skew
        if (i == 0) begin : g_direct
            assign ah[0][0] = lanes_in[0];
        end else begin : g_delay
            lane_t sk_q [i];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < i; k++) sk_q[k] <= '0;
                end else begin
                    sk_q[0] <= lanes_in[i];
                    for (int k = 1; k < i; k++) sk_q[k] <= sk_q[k-1];
                end
            end
            assign ah[i][0] = sk_q[i-1];
        end
    end

    // activation forwarding along each row
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N - 1; j++) begin : g_fwd
            always_ff @(posedge clk) begin
                if (rst) ah[i][j+1] <= '0;
                else     ah[i][j+1] <= ah[i][j];
            end
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_top
        assign pv[0][j] = '0;
    end

    for (genvar i = 0; i < N; i++) begin : g_ci
        for (genvar j = 0; j < N; j++) begin : g_cj
            ws_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .a_in   (ah[i][j]),
                .w_word (tile[i][j]),
                .ps_in  (pv[i][j]),
                .ps_out (pv[i+1][j])
            );
        end
    end

    // output deskew: column j waits N-1-j cycles
    for (genvar j = 0; j < N; j++) begin : g_deskew
        if (j == N - 1) begin : g_direct
            assign sums_out[j] = pv[N][j];
        end else begin : g_delay
            logic [SUM_W-1:0] dq [N-1-j];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < N - 1 - j; k++) dq[k] <= '0;
                end else begin
                    dq[0] <= pv[N][j];
                    for (int k = 1; k < N - 1 - j; k++) dq[k] <= dq[k-1];
                end
            end
            assign sums_out[j] = dq[N-2-j];
        end
    end

endmodule

// File: rtl/ws_wbank.sv
module ws_wbank
    import ws_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ld_valid,
    input  logic [N-1:0][OP_W-1:0]         ld_word,
    input  logic                           commit,
    output logic [N-1:0][N-1:0][OP_W-1:0]  active
);

    logic [N-1:0][N-1:0][OP_W-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (ld_valid) begin
            shadow[N-1] <= ld_word;
            for (int k = 0; k < N - 1; k++) shadow[k] <= shadow[k+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         active <= '0;
        else if (commit) active <= shadow;
    end

endmodule

// File: rtl/ws_combine.sv
module ws_combine
    import ws_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  tag_t                      tag,
    input  logic [N-1:0][SUM_W-1:0]   sums,
    output logic                      out_valid,
    output logic [N-1:0][SUM_W-1:0]   out_vec
);

    logic [N-1:0][SUM_W-1:0] acc_q, nxt;

    always_comb begin
        for (int j = 0; j < N; j++)
            nxt[j] = (tag.first ? '0 : acc_q[j]) + (sums[j] << tag.shamt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= tag.vld && tag.last;
            if (tag.vld) acc_q <= nxt;
        end
    end

    assign out_vec = acc_q;

endmodule

// File: rtl/ws_systolic_array.sv
module ws_systolic_array
    import ws_pkg::*;
#(
    parameter int N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [N*16-1:0]   in_data,
    input  logic              a_sgn,
    input  logic              w_sgn,
    input  logic              a_wide,
    input  logic              w_wide,
    input  logic              ld_valid,
    input  logic [N*16-1:0]   ld_row,
    input  logic              swap_req,
    output logic              out_valid,
    output logic [N*32-1:0]   out_data
);

    localparam int TAG_DLY = 2 * N - 1;
    localparam int CW      = $clog2(2 * N + 4) + 1;

    mode_t                          mode;
    lane_t [N-1:0]                  lanes;
    tag_t                           tag_in;
    tag_t                           tag_q [TAG_DLY];
    logic                           accept;
    logic                           pending_q, commit;
    logic [CW-1:0]                  infl_q;
    logic [N-1:0][N-1:0][OP_W-1:0]  act_tile;
    logic [N-1:0][SUM_W-1:0]        col_sums;
    logic [N-1:0][SUM_W-1:0]        res;
    logic [N-1:0][OP_W-1:0]         in_vec, ld_vec;

    assign mode   = '{a_sgn: a_sgn, w_sgn: w_sgn, a_wide: a_wide, w_wide: w_wide};
    assign in_vec = in_data;
    assign ld_vec = ld_row;
    assign commit = pending_q && (infl_q == '0);

    ws_issue #(.N(N)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_vec   (in_vec),
        .mode_i   (mode),
        .hold     (pending_q),
        .in_ready (in_ready),
        .accept   (accept),
        .lanes_o  (lanes),
        .tag_o    (tag_in)
    );

    ws_wbank #(.N(N)) u_wbank (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .ld_word  (ld_vec),
        .commit   (commit),
        .active   (act_tile)
    );

    ws_grid #(.N(N)) u_grid (
        .clk      (clk),
        .rst      (rst),
        .lanes_in (lanes),
        .tile     (act_tile),
        .sums_out (col_sums)
    );

    // pass control rides alongside the data through skew, grid and deskew
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAG_DLY; k++) tag_q[k] <= '0;
        end else begin
            tag_q[0] <= tag_in;
            for (int k = 1; k < TAG_DLY; k++) tag_q[k] <= tag_q[k-1];
        end
    end

    ws_combine #(.N(N)) u_comb (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag_q[TAG_DLY-1]),
        .sums      (col_sums),
        .out_valid (out_valid),
        .out_vec   (res)
    );

    assign out_data = res;

    always_ff @(posedge clk) begin
        if (rst) begin
            infl_q    <= '0;
            pending_q <= 1'b0;
        end else begin
            case ({accept, out_valid})
                2'b10:   infl_q <= infl_q + 1'b1;
                2'b01:   infl_q <= infl_q - 1'b1;
                default: infl_q <= infl_q;
            endcase
            pending_q <= (pending_q || swap_req) && !commit;
        end
    end

endmodule

// File: rtl/ws_systolic_array_chk.sv
module ws_systolic_array_chk #(
    parameter int N = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic                         in_ready,
    input logic                         a_wide,
    input logic                         w_wide,
    input logic                         swap_req,
    input logic                         out_valid,
    input logic [N-1:0][N-1:0][15:0]    act_tile
);

    logic       acc;
    logic [7:0] open_q;
    logic [1:0] age_q;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= '0;
            age_q  <= '0;
        end else begin
            open_q <= open_q + {7'd0, acc} - {7'd0, out_valid};
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    AST_FULL_RATE_READY: assert property (@(posedge clk) disable iff (rst)
        (acc && !a_wide && !w_wide && !swap_req) |=> in_ready);                  // R3
    AST_WIDE_STALL: assert property (@(posedge clk) disable iff (rst)
        (acc && (a_wide || w_wide)) |=> !in_ready);                              // R4
    AST_QUARTER_STALL: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(acc && a_wide && w_wide, 2)) |-> !in_ready);     // R5
    AST_SWAP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        swap_req |=> !in_ready);                                                 // R7
    AST_TILE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && !$stable(act_tile)) |-> ($past(open_q) == 8'd0));      // R7
    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (open_q != 8'd0));                                         // R8

endmodule

bind ws_systolic_array ws_systolic_array_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .a_wide    (a_wide),
    .w_wide    (w_wide),
    .swap_req  (swap_req),
    .out_valid (out_valid),
    .act_tile  (act_tile)
);

// File: tb/ws_systolic_array_tb.sv
module ws_systolic_array_tb;

    localparam int N  = 4;
    localparam int WD = 20000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0, a_sgn = 1'b0, w_sgn = 1'b0, a_wide = 1'b0, w_wide = 1'b0;
    logic            ld_valid = 1'b0, swap_req = 1'b0;
    logic [N*16-1:0] in_data = '0, ld_row = '0;
    logic            in_ready, out_valid;
    logic [N*32-1:0] out_data;

    int n_checks = 0, n_err = 0, cyc = 0;
    bit done = 0;

    logic [15:0]     m_act [N][N];
    logic [15:0]     m_shd [N][N];
    int              due_q [$];
    logic [N*32-1:0] val_q [$];
    string           req_q [$];
    string           cur_req = "R2";
    string           busy_req = "R4";
    int              busy_left = 0, sw_age = 0;
    bit              swap_wait = 0;

    ws_systolic_array #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .a_sgn(a_sgn), .w_sgn(w_sgn), .a_wide(a_wide), .w_wide(w_wide),
        .ld_valid(ld_valid), .ld_row(ld_row), .swap_req(swap_req),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [N*32-1:0] act,
                         input logic [N*32-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    function automatic longint opval(input logic [15:0] v, input logic sgn, input logic wide);
        if (wide) return sgn ? longint'($signed(v)) : longint'(v);
        return sgn ? longint'($signed(v[7:0])) : longint'(v[7:0]);
    endfunction

    function automatic logic [N*32-1:0] ref_vec(input logic [N*16-1:0] x, input logic as,
                                                input logic ws, input logic aw, input logic ww);
        logic [N*32-1:0] r;
        for (int j = 0; j < N; j++) begin
            longint s = 0;
            for (int i = 0; i < N; i++)
                s += opval(x[16*i +: 16], as, aw) * opval(m_act[i][j], ws, ww);
            r[32*j +: 32] = s[31:0];
        end
        return r;
    endfunction

    initial begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                m_act[i][j] = '0;
                m_shd[i][j] = '0;
            end
    end

    // reference model, compared every cycle away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int p;
            bit took;
            if (swap_wait) sw_age++;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                check(out_valid === 1'b1, req_q[0], N*32'(out_valid), 1);
                check(out_data === val_q[0], req_q[0], out_data, val_q[0]);
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(req_q.pop_front());
            end else begin
                check(out_valid === 1'b0, "R8", N*32'(out_valid), 0);
            end
            if (busy_left > 0) begin
                check(in_ready === 1'b0, busy_req, N*32'(in_ready), 0);
            end else if (swap_wait) begin
                if (sw_age == 1) check(in_ready === 1'b0, "R7", N*32'(in_ready), 0);
                if (in_ready && sw_age >= 2) swap_wait = 0;
            end else begin
                check(in_ready === 1'b1, "R3", N*32'(in_ready), 1);
            end
            took = in_valid && in_ready;
            if (took) begin
                p = (a_wide ? 2 : 1) * (w_wide ? 2 : 1);
                due_q.push_back(cyc + 2*N + p - 1);
                val_q.push_back(ref_vec(in_data, a_sgn, w_sgn, a_wide, w_wide));
                req_q.push_back(cur_req);
                busy_left = p - 1;
                busy_req  = (p == 4) ? "R5" : "R4";
            end else if (busy_left > 0) begin
                busy_left--;
            end
            if (swap_req) begin
                m_act = m_shd;
                swap_wait = 1;
                sw_age = 0;
            end
            if (ld_valid) begin
                for (int k = 0; k < N - 1; k++) m_shd[k] = m_shd[k+1];
                for (int j = 0; j < N; j++) m_shd[N-1][j] = ld_row[16*j +: 16];
            end
            if (cyc > WD) begin
                check(1'b0, "watchdog", cyc, WD);
                finish_run();
            end
        end
    end

    task automatic send(input logic [N*16-1:0] v, input logic as, input logic ws,
                        input logic aw, input logic ww);
        in_data = v; a_sgn = as; w_sgn = ws; a_wide = aw; w_wide = ww;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [N*16-1:0] rnd_vec();
        logic [N*16-1:0] v;
        for (int i = 0; i < N; i++) v[16*i +: 16] = 16'($urandom);
        return v;
    endfunction

    task automatic load_tile(input bit use_const, input logic [15:0] cval);
        for (int r = 0; r < N; r++) begin
            logic [N*16-1:0] w;
            w = rnd_vec();
            if (use_const) w = {N{cval}};
            ld_row = w;
            ld_valid = 1'b1;
            @(posedge clk); #1;
        end
        ld_valid = 1'b0;
    endtask

    task automatic do_swap();
        swap_req = 1'b1;
        @(posedge clk); #1;
        swap_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R1", N*32'(in_ready), 1);
        check(out_valid === 1'b0, "R1", N*32'(out_valid), 0);
        @(posedge clk); #1;

        // R1: active tile is zero after reset
        cur_req = "R1";
        send(rnd_vec(), 1'b1, 1'b1, 1'b0, 1'b0);
        idle(2*N + 2);

        // R2/R3: narrow operands, all signedness combinations, back to back
        load_tile(1'b0, 16'h0);
        do_swap();
        cur_req = "R2";
        for (int k = 0; k < 8; k++)
            send(rnd_vec(), k[0], k[1], 1'b0, 1'b0);
        cur_req = "R3";
        send({N{16'hAB80}}, 1'b1, 1'b0, 1'b0, 1'b0);
        send({N{16'h12FF}}, 1'b0, 1'b1, 1'b0, 1'b0);

        // R6: shadow load overlaps streaming; results stay on the active tile
        cur_req = "R6";
        fork
            for (int k = 0; k < 2*N; k++) send(rnd_vec(), 1'b1, 1'b1, 1'b0, 1'b0);
            load_tile(1'b0, 16'h0);
        join

        // R7: swap with vectors in flight, followed at once by new vectors
        cur_req = "R7";
        send(rnd_vec(), 1'b0, 1'b0, 1'b0, 1'b0);
        send(rnd_vec(), 1'b1, 1'b0, 1'b0, 1'b0);
        do_swap();
        for (int k = 0; k < 4; k++) send(rnd_vec(), 1'b1, 1'b1, 1'b0, 1'b0);

        // R4: one wide operand
        cur_req = "R4";
        for (int k = 0; k < 4; k++) send(rnd_vec(), k[0], k[1], 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) send(rnd_vec(), k[0], k[1], 1'b0, 1'b1);

        // R5: both wide, then wraparound corner
        cur_req = "R5";
        for (int k = 0; k < 4; k++) send(rnd_vec(), k[0], k[1], 1'b1, 1'b1);
        send({N{16'hFFFF}}, 1'b0, 1'b0, 1'b1, 1'b1);
        load_tile(1'b1, 16'h8000);
        do_swap();
        send({N{16'h8000}}, 1'b1, 1'b1, 1'b1, 1'b1);
        send({N{16'h8000}}, 1'b0, 1'b1, 1'b1, 1'b1);
        send({N{16'h7FFF}}, 1'b1, 1'b0, 1'b1, 1'b1);
        send({N{16'h0080}}, 1'b1, 1'b1, 1'b0, 1'b0);

        idle(3*N + 10);
        check(due_q.size() == 0, "R8", due_q.size(), 0);
        finish_run();
    end

endmodule